// File: doc/BRIEF.md
# Prioritized Dual Digital I/O Controller

This block owns two bidirectional pad lines and decides, every cycle, which of three functions drives each of them. A data-ready indicator has first claim, an alarm indicator second, and general-purpose I/O gets whatever is left. Software configures the block through two 16-bit registers, a miscellaneous control word and a GPIO control word, over a simple synchronous register bus. A write lands on the rising clock edge. A read is combinational from the selected register.

The data-ready function waits for a sample-tick input. It then drives a pulse that lasts one quarter of a sample period, where the period is a parameter counted in clock cycles. The pulse polarity and the target pin are both programmable. The alarm function takes a pin only when its external enable is set and its pin-select input points at that pin. It then copies the alarm-request level onto the pin. Pad input levels pass through a two-stage synchronizer and come back in the GPIO control word, so software always reads the real line level.

All pins are plain control signals. The register bus has no back-pressure: a write is accepted on every edge where the write strobe is high.

Top module: `dio_pin_arbiter`

## Requirements
- R1: After reset both registers read 0x0000, and both pads have output-enable low.
- R2: Miscellaneous control word (address 0): bit 2 enables data-ready, bit 1 selects polarity (1 = active high), and bit 0 selects the pin (1 = pin 1, 0 = pin 0). Every other bit is not stored and reads as zero.
- R3: GPIO control word (address 1): bits 0 and 1 set the direction of pin 0 and pin 1 (1 = output). Written bits 8 and 9 give the value that pin 0 and pin 1 drive when GPIO owns them. A write is seen on the pads in the cycle after its edge.
- R4: Reading the GPIO control word returns the direction in bits 1:0 and the synchronized level of pin 0 and pin 1 in bits 8 and 9. A pad change appears there after two rising edges. Every other bit reads as zero.
- R5: When data-ready is enabled, a sample tick sampled on an edge makes the pulse active for the next PERIOD_CYCLES/4 cycles, which is 4 with the defaults. A tick during a pulse restarts the full width.
- R6: With polarity 1 the data-ready pin is high while the pulse is active and low otherwise. With polarity 0 it is the inverse.
- R7: A pin selected by an enabled data-ready function is driven as an output with the data-ready level, whatever the alarm inputs and GPIO settings are.
- R8: When the alarm enable is high, the alarm pin-select (0 = pin 0, 1 = pin 1) names a pin, and data-ready does not own that pin, the pin is an output carrying the alarm-request level in the same cycle.
- R9: The GPIO direction and data settings of a claimed pin are kept. They take effect again as soon as the claim is released.
- R10: Clearing the data-ready enable ends any pulse in progress. After a later re-enable, no pulse starts until a new tick arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 = miscellaneous control, 1 = GPIO control |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register (combinational) |
| sample_tick | input | 1 | One-cycle marker for the start of a sample period |
| alarm_en | input | 1 | Alarm indicator enable |
| alarm_pin_sel | input | 1 | Pin claimed by the alarm indicator |
| alarm_level | input | 1 | Level driven on the alarm pin |
| pad_in | input | 2 | Levels seen at the two pads |
| pad_oe | output | 2 | Output enable of the two pads |
| pad_out | output | 2 | Output value of the two pads |

## Verification
Each result has its own latency. A register write is due on the pads and on reads one cycle after its edge. The alarm inputs reach the pads in the same cycle. A tick starts the data-ready pulse one cycle later, and the pulse lasts PERIOD_CYCLES/4 cycles. A pad level reaches the read data two edges after it changes. The bench steps a behavioural model on each rising edge, using the same inputs the design samples there. It then compares the pads and the read data against that model at the following falling edge, once every register on the path has settled, so every latency is checked in the exact cycle it is due.

// File: rtl/dio_pkg.sv
package dio_pkg;
  localparam int REG_W    = 16;
  localparam int NUM_PINS = 2;

  localparam logic ADDR_MISC = 1'b0;
  localparam logic ADDR_GPIO = 1'b1;

  // field positions software depends on
  localparam int MISC_EN_BIT  = 2;
  localparam int MISC_POL_BIT = 1;
  localparam int MISC_SEL_BIT = 0;
  localparam int GPIO_DIR_LSB = 0;
  localparam int GPIO_DAT_LSB = 8;

  typedef struct packed {
    logic dr_en;
    logic dr_pol;
    logic dr_sel;
  } misc_t;

  typedef struct packed {
    logic [NUM_PINS-1:0] dir;
    logic [NUM_PINS-1:0] dout;
  } gpio_t;
endpackage

// File: rtl/dio_sync.sv
module dio_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= din;
      for (int s = 1; s < STAGES; s++) begin
        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/dio_ready_pulse.sv
module dio_ready_pulse #(
  parameter int PERIOD_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic tick,
  output logic active
);
  localparam int PULSE_CYCLES = PERIOD_CYCLES / 4;
  localparam int CW           = $clog2(PULSE_CYCLES + 1);

  logic [CW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
    end else if (!enable) begin
      left_q <= '0;
    end else if (tick) begin
      left_q <= CW'(PULSE_CYCLES);
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
    end
  end

  assign active = (left_q != '0);
endmodule

// File: rtl/dio_regs.sv
module dio_regs
  import dio_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr,
  input  logic                addr,
  input  logic [REG_W-1:0]    wdata,
  input  logic [NUM_PINS-1:0] pin_level,
  output misc_t               misc_q,
  output gpio_t               gpio_q,
  output logic [REG_W-1:0]    rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      misc_q <= '0;
      gpio_q <= '0;
    end else if (wr) begin
      if (addr == ADDR_MISC) begin
        misc_q.dr_en  <= wdata[MISC_EN_BIT];
        misc_q.dr_pol <= wdata[MISC_POL_BIT];
        misc_q.dr_sel <= wdata[MISC_SEL_BIT];
      end else begin
        gpio_q.dir  <= wdata[GPIO_DIR_LSB +: NUM_PINS];
        gpio_q.dout <= wdata[GPIO_DAT_LSB +: NUM_PINS];
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_GPIO) begin
      rdata[GPIO_DIR_LSB +: NUM_PINS] = gpio_q.dir;
      rdata[GPIO_DAT_LSB +: NUM_PINS] = pin_level;
    end else begin
      rdata[MISC_EN_BIT]  = misc_q.dr_en;
      rdata[MISC_POL_BIT] = misc_q.dr_pol;
      rdata[MISC_SEL_BIT] = misc_q.dr_sel;
    end
  end
endmodule

// File: rtl/dio_pin_arbiter.sv
module dio_pin_arbiter
  import dio_pkg::*;
#(
  parameter int PERIOD_CYCLES = 16,
  parameter int SYNC_STAGES   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic                reg_addr,
  input  logic [REG_W-1:0]    reg_wdata,
  output logic [REG_W-1:0]    reg_rdata,
  input  logic                sample_tick,
  input  logic                alarm_en,
  input  logic                alarm_pin_sel,
  input  logic                alarm_level,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic [NUM_PINS-1:0] pad_out
);
  misc_t               misc_q;
  gpio_t               gpio_q;
  logic [NUM_PINS-1:0] sync_lvl;
  logic                pulse_on;

  dio_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (pad_in),
    .dout  (sync_lvl)
  );

  dio_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (reg_wr),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .pin_level (sync_lvl),
    .misc_q    (misc_q),
    .gpio_q    (gpio_q),
    .rdata     (reg_rdata)
  );

  dio_ready_pulse #(.PERIOD_CYCLES(PERIOD_CYCLES)) u_pulse (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (misc_q.dr_en),
    .tick   (sample_tick),
    .active (pulse_on)
  );

  // fixed-priority owner per pin: data-ready, then alarm, then GPIO
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic dr_claim;
    logic al_claim;
    logic dr_level;

    assign dr_claim = misc_q.dr_en && (int'(misc_q.dr_sel) == p);
    assign al_claim = alarm_en && (int'(alarm_pin_sel) == p) && !dr_claim;
    assign dr_level = misc_q.dr_pol ? pulse_on : ~pulse_on;

    assign pad_oe[p]  = dr_claim | al_claim | gpio_q.dir[p];
    assign pad_out[p] = dr_claim ? dr_level :
                        (al_claim ? alarm_level : gpio_q.dout[p]);
  end
endmodule

// File: rtl/dio_pin_arbiter_chk.sv
module dio_pin_arbiter_chk
  import dio_pkg::*;
#(
  parameter int PERIOD_CYCLES = 16,
  parameter int SYNC_STAGES   = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                sample_tick,
  input logic                alarm_en,
  input logic                alarm_pin_sel,
  input logic                alarm_level,
  input logic [NUM_PINS-1:0] pad_in,
  input logic [NUM_PINS-1:0] pad_oe,
  input logic [NUM_PINS-1:0] pad_out,
  input misc_t               misc_q,
  input gpio_t               gpio_q,
  input logic                pulse_on,
  input logic [NUM_PINS-1:0] sync_lvl
);
  localparam int PULSE_CYCLES = PERIOD_CYCLES / 4;

  int run_len;
  int since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_len   <= 0;
      since_rst <= 0;
    end else begin
      if (since_rst < SYNC_STAGES) since_rst <= since_rst + 1;
      if (sample_tick && misc_q.dr_en) run_len <= 0;
      else if (pulse_on)               run_len <= run_len + 1;
      else                             run_len <= 0;
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (misc_q == '0 && gpio_q == '0));

  assert_pulse_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_tick && misc_q.dr_en) |=> pulse_on);

  assert_pulse_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_on |-> (run_len < PULSE_CYCLES));

  assert_disable_stops_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !misc_q.dr_en |=> !pulse_on);

  if (SYNC_STAGES == 2) begin : g_sync_chk
    assert_sync_delay_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst >= 2) |-> (sync_lvl == $past(pad_in, 2)));
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin_chk
    assert_dr_owns_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (misc_q.dr_en && int'(misc_q.dr_sel) == p) |->
        (pad_oe[p] && pad_out[p] == (misc_q.dr_pol ? pulse_on : !pulse_on)));

    assert_alarm_drives_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (alarm_en && int'(alarm_pin_sel) == p &&
       !(misc_q.dr_en && int'(misc_q.dr_sel) == p)) |->
        (pad_oe[p] && pad_out[p] == alarm_level));
  end
endmodule

bind dio_pin_arbiter dio_pin_arbiter_chk #(
  .PERIOD_CYCLES (PERIOD_CYCLES),
  .SYNC_STAGES   (SYNC_STAGES)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .sample_tick   (sample_tick),
  .alarm_en      (alarm_en),
  .alarm_pin_sel (alarm_pin_sel),
  .alarm_level   (alarm_level),
  .pad_in        (pad_in),
  .pad_oe        (pad_oe),
  .pad_out       (pad_out),
  .misc_q        (misc_q),
  .gpio_q        (gpio_q),
  .pulse_on      (pulse_on),
  .sync_lvl      (sync_lvl)
);

// File: tb/dio_pin_arbiter_tb.sv
module dio_pin_arbiter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PERIOD_CYCLES = 16;
  localparam int PULSE = PERIOD_CYCLES / 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_addr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        sample_tick = 1'b0;
  logic        alarm_en = 1'b0;
  logic        alarm_pin_sel = 1'b0;
  logic        alarm_level = 1'b0;
  logic [1:0]  pad_in = '0;
  logic [1:0]  pad_oe;
  logic [1:0]  pad_out;

  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  // behavioural reference state
  bit       m_en, m_pol, m_sel;
  bit [1:0] m_dir, m_dout, m_s1, m_s2;
  int       m_left;

  always #(CLK_PERIOD/2) clk = ~clk;

  dio_pin_arbiter #(.PERIOD_CYCLES(PERIOD_CYCLES)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sample_tick(sample_tick),
    .alarm_en(alarm_en), .alarm_pin_sel(alarm_pin_sel), .alarm_level(alarm_level),
    .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_pol = 0; m_sel = 0;
      m_dir = 0; m_dout = 0; m_s1 = 0; m_s2 = 0; m_left = 0;
    end else begin
      if (!m_en) m_left = 0;
      else if (sample_tick) m_left = PULSE;
      else if (m_left > 0) m_left = m_left - 1;
      m_s2 = m_s1;
      m_s1 = pad_in;
      if (reg_wr) begin
        if (!reg_addr) begin
          m_en = reg_wdata[2]; m_pol = reg_wdata[1]; m_sel = reg_wdata[0];
        end else begin
          m_dir = reg_wdata[1:0]; m_dout = reg_wdata[9:8];
        end
      end
    end
  end

  task automatic compare(string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  task automatic check_now();
    logic [1:0]  e_oe, e_out;
    logic [15:0] e_rd;
    for (int p = 0; p < 2; p++) begin
      bit drc, alc, act;
      drc = m_en && (int'(m_sel) == p);
      alc = alarm_en && (int'(alarm_pin_sel) == p) && !drc;
      act = (m_left > 0);
      e_oe[p]  = drc || alc || m_dir[p];
      e_out[p] = drc ? (m_pol ? act : !act) : (alc ? alarm_level : m_dout[p]);
    end
    e_rd = reg_addr ? {6'b0, m_s2, 6'b0, m_dir} : {13'b0, m_en, m_pol, m_sel};
    compare("pad_oe", 16'(pad_oe), 16'(e_oe));
    compare("pad_out", 16'(pad_out), 16'(e_out));
    compare("reg_rdata", reg_rdata, e_rd);
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_now();
      if (!reg_wr) reg_addr = ~reg_addr;
    end
  endtask

  task automatic wr(logic a, logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    cyc(1);
    reg_wr = 1'b0;
  endtask

  task automatic tick();
    sample_tick = 1'b1;
    cyc(1);
    sample_tick = 1'b0;
  endtask

  initial begin
    cur_req = "R1";
    cyc(3);
    rst_n = 1'b1;
    cyc(2);

    cur_req = "R3";
    wr(1'b1, 16'h0002); cyc(2);
    wr(1'b1, 16'h0303); cyc(2);

    cur_req = "R4";
    wr(1'b1, 16'hFCFC);
    pad_in = 2'b10; cyc(4);
    pad_in = 2'b01; cyc(4);

    cur_req = "R2";
    wr(1'b0, 16'hFFF8); cyc(2);
    wr(1'b0, 16'h0005); cyc(2);

    cur_req = "R5";
    tick(); cyc(6);
    tick(); cyc(2);
    tick(); cyc(6);

    cur_req = "R6";
    wr(1'b0, 16'h0006); cyc(1);
    tick(); cyc(6);

    cur_req = "R7";
    wr(1'b1, 16'h0303);
    alarm_en = 1'b1; alarm_pin_sel = 1'b0; alarm_level = 1'b1; cyc(3);
    tick(); cyc(3);
    alarm_level = 1'b0; cyc(4);

    cur_req = "R8";
    alarm_pin_sel = 1'b1; cyc(2);
    alarm_level = 1'b1; cyc(2);
    wr(1'b0, 16'h0000);
    alarm_pin_sel = 1'b0; cyc(2);
    alarm_level = 1'b0; cyc(2);

    cur_req = "R10";
    alarm_en = 1'b0;
    wr(1'b0, 16'h0005);
    tick(); cyc(1);
    wr(1'b0, 16'h0001); cyc(3);
    wr(1'b0, 16'h0005); cyc(3);

    cur_req = "R9";
    wr(1'b1, 16'h0102); cyc(2);
    wr(1'b0, 16'h0000); cyc(3);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule